// File: doc/BRIEF.md
# Adaptive Rectifier Turn-Off Timer

This block decides, for one synchronous-rectifier channel, the instant at which the gate is released. It works on digitized comparator events that are already synchronous to the system clock. The events are a gate-on request, a drain-source zero-crossing level, a body-diode conduction level seen after the gate drops, and a fast zero-current trip. All time is counted in system-clock ticks against a measured converter clock period `period`.

There are two turn-off paths. The slow (adaptive) path releases the gate a learned number of ticks `dly_code` after the zero crossing. It is masked for the first half of the period. After each slow turn-off the residual diode conduction is measured, and `dly_code` moves one step toward the target. The fast path trips on the zero-current comparator once a short blanking window after turn-on has passed. After a fast turn-off with excess diode conduction, the threshold code `zth_code` for that comparator is raised in proportion to the excess. This pushes the threshold so that, in steady state, the slow path does the work.

After reset or a `reload` request, the first turn-off is forced at half the period, and adaptation then proceeds from that point. No pin carries a data stream: every pin is a plain level or a one-cycle pulse, so no back-pressure applies.

Top module: `adt_off_timer`

## Requirements
- R1: During and after reset, `gate_drv`, `off_pulse` and `off_fast` are 0, `dly_code` equals `period>>1` (P/2), and `zth_code` equals 0.
- R2: The first conduction after reset or reload is in start mode: the gate drops after cycle n = P/2, so `gate_drv` is high for P/2+1 cycles. This turn-off is slow, and zero crossing is ignored.
- R3: Outside start mode, n counts the high cycles of `gate_drv` from 0, and z is the first n at which `vds_zero` is sampled high. The slow path drops the gate after the first n with n >= P/2 and n >= z+1+D, where D is `dly_code`.
- R4: `zc_fast` drops the gate after the first n with n >= BLANK (default 38). A trip before BLANK is ignored. If both paths fire in the same cycle, the turn-off is fast.
- R5: After the gate drops, the residual is the number of consecutive cycles in which `diode_cond` is high, starting in the first cycle after the drop. The measurement ends at the first low sample, and the update is visible the cycle after.
- R6: After a slow turn-off, `dly_code` rises by 1 if the residual exceeds TGT (default 9), falls by 1 if it is below TGT, and holds if it is equal. The rise is capped at P and the fall stops at 0.
- R7: After a fast turn-off with residual r > TGT, `zth_code` grows by (r-TGT)>>ZGAIN and saturates at 2^ZW-1. A fast turn-off leaves `dly_code` unchanged. A slow turn-off leaves `zth_code` unchanged.
- R8: `off_pulse` is high for exactly the one cycle in which `gate_drv` is first low. `off_fast` (1 = fast, 0 = slow) is set at that cycle and held until the next turn-off.
- R9: `gate_on` is ignored while the gate is high or a measurement is in progress. `gate_drv` stays 0 through the measurement.
- R10: A synchronous `reload` drops the gate, restores the R1 values on the next cycle, and re-enters start mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reload | input | 1 | Restore startup behaviour (synchronous) |
| period | input | PW | Measured converter clock period in ticks |
| gate_on | input | 1 | Request to raise the gate (accepted when idle) |
| vds_zero | input | 1 | Sensed drain-source voltage has reached zero |
| zc_fast | input | 1 | Fast zero-current comparator trip |
| diode_cond | input | 1 | Body diode conducting after turn-off |
| gate_drv | output | 1 | Gate command |
| off_pulse | output | 1 | One-cycle turn-off marker |
| off_fast | output | 1 | Type of last turn-off (1 = fast) |
| dly_code | output | PW | Learned delay after zero crossing |
| zth_code | output | ZW | Fast-comparator threshold code |

## Verification
The bench runs conduction cycles in several patterns: zero crossings before and after the half-period mask, fast trips inside and outside the blanking window, and a fast trip that lands in the same cycle as the slow condition. A design that counts the delay from turn-on, or that lets the mask end a cycle early, misplaces the drop by one or more cycles. A design that gives the slow path priority in a tie reports the wrong type. Long runs drive `dly_code` to 0 and to P and drive `zth_code` to its ceiling, which exposes wraparound. A gate-on pulse during measurement and a reload after adaptation check that the state machine neither re-fires nor keeps learned values.

// File: rtl/adt_pkg.sv
package adt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_MEAS = 2'd2
  } phase_e;
endpackage

// File: rtl/adt_phase_timer.sv
// Counts ticks of gate conduction and ticks since the zero crossing.
module adt_phase_timer #(
  parameter int PW    = 12,
  parameter int BLANK = 38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          vds_zero,
  input  logic [PW-1:0] half,
  output logic [PW-1:0] on_cnt,
  output logic [PW-1:0] zcnt,
  output logic          zero_seen,
  output logic          blank_done,
  output logic          mask_done
);
  localparam logic [PW-1:0] BLANK_C = PW'(BLANK);
  localparam logic [PW-1:0] CMAX    = {PW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      on_cnt    <= '0;
      zcnt      <= '0;
      zero_seen <= 1'b0;
    end else if (run) begin
      if (on_cnt != CMAX) on_cnt <= on_cnt + 1'b1;
      if (!zero_seen) begin
        if (vds_zero) begin
          zero_seen <= 1'b1;
          zcnt      <= '0;
        end
      end else if (zcnt != CMAX) begin
        zcnt <= zcnt + 1'b1;
      end
    end
  end

  assign blank_done = (on_cnt >= BLANK_C);
  assign mask_done  = (on_cnt >= half);

  p_zcnt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_seen && !clr) |=> (zcnt == '0));
endmodule

// File: rtl/adt_diode_meter.sv
// Measures residual body-diode conduction after turn-off.
module adt_diode_meter #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  output logic [PW-1:0] dcnt
);
  localparam logic [PW-1:0] CMAX = {PW{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr)                 dcnt <= '0;
    else if (run && dcnt != CMAX)      dcnt <= dcnt + 1'b1;
  end

  p_meter_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> (dcnt >= $past(dcnt)));
endmodule

// File: rtl/adt_tuner.sv
// Closed-loop update of the turn-off delay and the fast threshold code.
module adt_tuner #(
  parameter int PW    = 12,
  parameter int ZW    = 6,
  parameter int TGT   = 9,
  parameter int ZGAIN = 0,
  parameter int ZINIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [PW-1:0] period,
  input  logic          upd,
  input  logic          upd_fast,
  input  logic [PW-1:0] dcnt,
  output logic [PW-1:0] dly,
  output logic [ZW-1:0] zth
);
  localparam logic [PW-1:0]    TGT_C = PW'(TGT);
  localparam int               SW    = PW + ZW + 1;
  localparam logic [SW-1:0]    ZMAX  = SW'((1 << ZW) - 1);

  logic [PW-1:0] excess;
  logic [SW-1:0] zsum;
  logic [ZW-1:0] zth_next;
  logic [PW-1:0] dly_up, dly_dn;

  always_comb begin
    excess   = (dcnt - TGT_C) >> ZGAIN;
    zsum     = {{(PW+1){1'b0}}, zth} + {{(ZW+1){1'b0}}, excess};
    zth_next = (zsum > ZMAX) ? ZMAX[ZW-1:0] : zsum[ZW-1:0];
    dly_up   = (dly >= period) ? period : dly + 1'b1;
    dly_dn   = (dly == '0) ? '0 : dly - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || reload) begin
      dly <= period >> 1;
      zth <= ZW'(ZINIT);
    end else if (upd) begin
      if (upd_fast) begin
        if (dcnt > TGT_C) zth <= zth_next;
      end else begin
        if (dcnt > TGT_C)      dly <= dly_up;
        else if (dcnt < TGT_C) dly <= dly_dn;
      end
    end
  end

  p_dly_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reload) |-> ({1'b0, dly} <= {1'b0, $past(dly)} + 1'b1));
  p_zth_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reload) |-> (zth >= $past(zth)));
  p_zth_hold_slow_r7: assert property (@(posedge clk) disable iff (!rst_n || reload)
    (upd && !upd_fast) |=> $stable(zth));
  p_dly_hold_fast_r7: assert property (@(posedge clk) disable iff (!rst_n || reload)
    (upd && upd_fast) |=> $stable(dly));
endmodule

// File: rtl/adt_off_timer.sv
// Top: per-channel turn-off decision with adaptive and fast paths.
module adt_off_timer #(
  parameter int PW    = 12,
  parameter int ZW    = 6,
  parameter int BLANK = 38,
  parameter int TGT   = 9,
  parameter int ZGAIN = 0,
  parameter int ZINIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [PW-1:0] period,
  input  logic          gate_on,
  input  logic          vds_zero,
  input  logic          zc_fast,
  input  logic          diode_cond,
  output logic          gate_drv,
  output logic          off_pulse,
  output logic          off_fast,
  output logic [PW-1:0] dly_code,
  output logic [ZW-1:0] zth_code
);
  import adt_pkg::*;

  phase_e        st;
  logic          start_q;
  logic [PW-1:0] half;
  logic [PW-1:0] on_cnt, zcnt, dcnt;
  logic          zero_seen, blank_done, mask_done;
  logic          in_on, in_meas, fire_fast, fire_slow, fire, meas_end;

  assign half      = period >> 1;
  assign in_on     = (st == PH_ON);
  assign in_meas   = (st == PH_MEAS);
  assign fire_fast = in_on && zc_fast && blank_done;
  assign fire_slow = in_on && mask_done &&
                     (start_q || (zero_seen && zcnt >= dly_code));
  assign fire      = fire_fast || fire_slow;
  assign meas_end  = in_meas && !diode_cond && !reload;

  adt_phase_timer #(.PW(PW), .BLANK(BLANK)) u_phase (
    .clk(clk), .rst_n(rst_n),
    .clr(st == PH_IDLE && gate_on), .run(in_on),
    .vds_zero(vds_zero), .half(half),
    .on_cnt(on_cnt), .zcnt(zcnt), .zero_seen(zero_seen),
    .blank_done(blank_done), .mask_done(mask_done)
  );

  adt_diode_meter #(.PW(PW)) u_meter (
    .clk(clk), .rst_n(rst_n),
    .clr(fire), .run(in_meas && diode_cond),
    .dcnt(dcnt)
  );

  adt_tuner #(.PW(PW), .ZW(ZW), .TGT(TGT), .ZGAIN(ZGAIN), .ZINIT(ZINIT)) u_tune (
    .clk(clk), .rst_n(rst_n), .reload(reload), .period(period),
    .upd(meas_end), .upd_fast(off_fast), .dcnt(dcnt),
    .dly(dly_code), .zth(zth_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || reload) begin
      st        <= PH_IDLE;
      start_q   <= 1'b1;
      off_pulse <= 1'b0;
      off_fast  <= 1'b0;
    end else begin
      off_pulse <= 1'b0;
      case (st)
        PH_IDLE: if (gate_on) st <= PH_ON;
        PH_ON: if (fire) begin
          st        <= PH_MEAS;
          off_pulse <= 1'b1;
          off_fast  <= fire_fast;
          start_q   <= 1'b0;
        end
        PH_MEAS: if (!diode_cond) st <= PH_IDLE;
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign gate_drv = in_on;

  p_pulse_after_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off_pulse |-> $past(gate_drv));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off_pulse |=> !off_pulse);
  p_fast_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (off_pulse && off_fast) |-> ($past(on_cnt) >= PW'(BLANK)));
  p_slow_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (off_pulse && !off_fast) |-> $past(mask_done));
  p_no_refire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_meas |=> !gate_drv);
endmodule

// File: tb/sim_adt_off_timer.sv
module sim_adt_off_timer;
  localparam int PW = 12;
  localparam int ZW = 6;
  localparam int BLANK = 38;
  localparam int TGT = 9;
  localparam int ZMAXV = 63;
  localparam int NV = 10;
  localparam int INF = 1000000;
  // zero-crossing tick, fast-trip tick (-1 none), residual length, expected type
  localparam int VZ [NV] = '{30, 30, 30, 30, 10, 90,  0,  0,  0,  20};
  localparam int VF [NV] = '{-1, -1, -1, -1, -1, 60, 10, 51, -1, 100};
  localparam int VD [NV] = '{12, 12,  5,  9,  3, 20, 15,  9,  0,  10};
  localparam int VX [NV] = '{ 0,  0,  0,  0,  0,  1,  1,  1,  0,   0};

  logic clk = 0, rst_n = 0, reload = 0, gate_on = 0, vds_zero = 0, zc_fast = 0, diode_cond = 0;
  logic [PW-1:0] period = 12'd100;
  logic gate_drv, off_pulse, off_fast;
  logic [PW-1:0] dly_code;
  logic [ZW-1:0] zth_code;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_dly, m_zth, per;
  bit m_start;

  always #4 clk = ~clk;

  adt_off_timer #(.PW(PW), .ZW(ZW), .BLANK(BLANK), .TGT(TGT)) u0 (
    .clk(clk), .rst_n(rst_n), .reload(reload), .period(period),
    .gate_on(gate_on), .vds_zero(vds_zero), .zc_fast(zc_fast), .diode_cond(diode_cond),
    .gate_drv(gate_drv), .off_pulse(off_pulse), .off_fast(off_fast),
    .dly_code(dly_code), .zth_code(zth_code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL R3 watchdog: cycles %0d expected below %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dly = per / 2; m_zth = 0; m_start = 1;
  endtask

  // One conduction cycle plus measurement; checks placement, type, pulse and updates.
  task automatic run_cycle(input int za, input int fa, input int dl, input int xf,
                           input bit gon_meas, input bit full);
    int half, ks, kfa, kf, k, got_pulse, got_fast, isf;
    bit fired;
    half = per / 2;
    if (m_start) ks = half;
    else if (za < 0) ks = INF;
    else ks = (za + 1 + m_dly > half) ? za + 1 + m_dly : half;
    kfa = (fa < 0) ? INF : ((fa > BLANK) ? fa : BLANK);
    isf = (kfa <= ks) ? 1 : 0;
    kf  = isf ? kfa : ks;
    @(negedge clk); gate_on = 1;
    @(negedge clk); gate_on = 0;
    k = 0; fired = 0; got_pulse = 0; got_fast = 0;
    while (!fired && k < 400) begin
      vds_zero = (za >= 0 && k >= za);
      zc_fast  = (fa >= 0 && k >= fa);
      @(posedge clk); #1;
      if (!gate_drv) begin
        fired = 1; got_pulse = off_pulse; got_fast = off_fast;
      end else k = k + 1;
    end
    vds_zero = 0; zc_fast = 0;
    // residual measurement
    for (int m = 0; m <= dl; m++) begin
      diode_cond = (m < dl);
      gate_on = gon_meas && (m == 0);
      @(posedge clk); #1;
      if (gon_meas) chk("R9 gate stays low in measurement", gate_drv, 0);
      gate_on = 0;
    end
    diode_cond = 0;
    m_start = 0;
    if (isf) begin
      if (dl > TGT) m_zth = (m_zth + dl - TGT > ZMAXV) ? ZMAXV : m_zth + dl - TGT;
    end else begin
      if (dl > TGT) m_dly = (m_dly >= per) ? per : m_dly + 1;
      else if (dl < TGT) m_dly = (m_dly == 0) ? 0 : m_dly - 1;
    end
    if (full) begin
      chk("R3/R4 turn-off tick", k, kf);
      chk("R8 off_pulse at drop", got_pulse, 1);
      chk("R4 turn-off type", got_fast, (xf < 0) ? isf : xf);
      chk("R6 delay after update", dly_code, m_dly);
      chk("R7 threshold after update", zth_code, m_zth);
      @(negedge clk);
      chk("R8 pulse lasts one cycle", off_pulse, 0);
      chk("R8 type held", off_fast, isf);
    end
    if (gon_meas) begin
      @(negedge clk);
      chk("R9 ignored gate_on left idle", gate_drv, 0);
    end
  endtask

  initial begin
    per = 100;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", gate_drv, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 gate after reset", gate_drv, 0);
    chk("R1 pulse after reset", off_pulse, 0);
    chk("R1 type after reset", off_fast, 0);
    chk("R1 delay seed", dly_code, 50);
    chk("R1 threshold seed", zth_code, 0);

    // vector table: R2 start cycle first, then R3/R4/R5/R6/R7
    for (int i = 0; i < NV; i++) run_cycle(VZ[i], VF[i], VD[i], VX[i], 0, 1);

    // R9: gate_on during measurement is ignored
    run_cycle(0, -1, 4, 0, 1, 1);

    // R6: delay saturates at zero
    for (int i = 0; i < 60; i++) run_cycle(0, -1, 0, 0, 0, 0);
    chk("R6 delay floor", dly_code, 0);
    run_cycle(0, -1, 0, 0, 0, 1);

    // R10: reload restores seed and start mode
    @(negedge clk); reload = 1;
    @(negedge clk); reload = 0;
    model_reset();
    chk("R10 delay reseeded", dly_code, 50);
    chk("R10 threshold reseeded", zth_code, 0);
    chk("R10 gate low", gate_drv, 0);
    run_cycle(5, -1, 9, 0, 0, 1);   // R2 start-mode drop at half

    // R7: threshold saturates
    run_cycle(-1, 40, 70, 1, 0, 1);
    run_cycle(-1, 40, 70, 1, 0, 1);
    chk("R7 threshold ceiling", zth_code, ZMAXV);

    // R6: delay capped at period after shrinking the period
    per = 16; period = 12'd16;
    @(negedge clk); reload = 1;
    @(negedge clk); reload = 0;
    model_reset();
    for (int i = 0; i < 12; i++) run_cycle(0, -1, 20, 0, 0, 0);
    chk("R6 delay ceiling", dly_code, 16);
    run_cycle(0, -1, 20, 0, 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule